// File: doc/BRIEF.md
# Instruction Bus-Cycle Sequencer

This block plays out the external bus activity of a handful of 8-bit processor instructions, one T-state per clock. A caller loads the register values it holds (program counter, HL, DE, BC, stack pointer and one 16-bit index register), picks an instruction with a 3-bit selector and pulses `start`. The block then walks through the opcode fetches, operand reads, internal cycles and memory reads and writes that the instruction needs. In every T-state it drives the address, the write data with its output enable, and the active-low strobes. It captures read data at the end of each read cycle.

The instructions covered are these: store the index register to a direct address; copy HL or the index register into the stack pointer; block move with increment or decrement; push and pop of the index register. After the last T-state the block raises `done` for one clock and presents the updated register values. Opcode decoding, arithmetic, flags, interrupts, wait states and I/O cycles are handled elsewhere.

Top module: `busseq_top`

## Requirements
- R1: A bus machine cycle lasts three clocks, T1, T2 and T3, and an internal machine cycle lasts one clock (Ti). `tstate` reads 0 when idle, 1/2/3 in T1/T2/T3 and 4 in Ti. `mcyc` gives the 0-based index of the current machine cycle and stays constant within it.
- R2: All strobes are active-low. `mreq_n` and `rd_n` are low in T2 and T3 of every fetch, operand-read and data-read cycle. `mreq_n` and `wr_n` are low in T2 and T3 of every write cycle. Every strobe is high in Ti and while idle.
- R3: `m1_n` is low during T1 to T3 of opcode fetch cycles only.
- R4: `dout_oe` is 1 during T1 to T3 of write cycles and 0 at all other times, which leaves the data bus undriven in Ti. `dout` is 0 when `dout_oe` is 0, and `addr` is 0 in Ti and while idle.
- R5: Selector 0 (store index) runs these cycles: two fetches at PC and PC+1, operand reads at PC+2 (low address byte) and PC+3 (high address byte), one Ti, a write of the index low byte at the assembled address, then a write of the index high byte at that address plus 1.
- R6: Selector 1 runs one fetch and one Ti and leaves SP equal to HL. Selector 2 runs two fetches and one Ti and leaves SP equal to the index register.
- R7: Selectors 3 (increment) and 4 (decrement) run two fetches, a read at HL, then a write of the byte just read at DE. HL and DE then step by +1 or -1 and BC drops by 1, all modulo 2^16.
- R8: Selector 5 (pop) runs two fetches, then reads the low byte at SP and the high byte at SP+1. It ends with the index register equal to {high, low} and SP equal to SP+2, modulo 2^16.
- R9: Selector 6 (push) runs two fetches, then writes the index high byte at SP-1 and the index low byte at SP-2. It ends with SP equal to SP-2, modulo 2^16.
- R10: Opcode fetches and operand reads use successive PC values. `pc_out` ends at PC plus the number of such cycles.
- R11: `done` is high for exactly one clock, the clock after the last T-state, while `busy` is already low. The result outputs are valid in that clock.
- R12: `start` has no effect while busy. `start` with selector 7 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| instr_sel | input | 3 | Instruction selector, 0 to 6 valid |
| pc_in | input | 16 | Program counter at start |
| hl_in | input | 16 | HL at start |
| de_in | input | 16 | DE at start |
| bc_in | input | 16 | BC at start |
| sp_in | input | 16 | Stack pointer at start |
| idx_in | input | 16 | Index register at start |
| rdata | input | 8 | Read data, sampled at the end of T3 |
| addr | output | 16 | Address bus |
| dout | output | 8 | Write data |
| dout_oe | output | 1 | Write data output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| mreq_n | output | 1 | Memory request, active low |
| m1_n | output | 1 | Opcode fetch marker, active low |
| mcyc | output | 3 | Machine cycle index |
| tstate | output | 3 | T-state code |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-clock completion pulse |
| pc_out | output | 16 | Program counter after the instruction |
| hl_out | output | 16 | HL after the instruction |
| de_out | output | 16 | DE after the instruction |
| bc_out | output | 16 | BC after the instruction |
| sp_out | output | 16 | Stack pointer after the instruction |
| idx_out | output | 16 | Index register after the instruction |

## Verification
If the machine-cycle counter or the T-state register takes a wrong value, the very next clock shows a wrong `addr`, strobe pattern, `mcyc` or `tstate`. The bench compares every busy clock against a queue of expected bus states, so such an error is reported within one cycle. A wrong captured byte or a wrong step of a pointer shows up later: in the data written at DE, in the second address of the direct store, or in the register outputs in the `done` clock. Ignored starts are shown by an unchanged bus sequence and a block that stays idle afterwards.

// File: rtl/busseq_pkg.sv
// Shared types for the bus-cycle sequencer: selector codes, T-state codes,
// machine-cycle kinds and the per-cycle step descriptor.
package busseq_pkg;

    typedef enum logic [2:0] {
        SEL_STIDX = 3'd0,
        SEL_HL2SP = 3'd1,
        SEL_IX2SP = 3'd2,
        SEL_XINC  = 3'd3,
        SEL_XDEC  = 3'd4,
        SEL_POP   = 3'd5,
        SEL_PUSH  = 3'd6,
        SEL_NONE  = 3'd7
    } sel_e;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_T1   = 3'd1,
        TS_T2   = 3'd2,
        TS_T3   = 3'd3,
        TS_TI   = 3'd4
    } ts_e;

    typedef enum logic [2:0] {
        MK_FETCH,
        MK_OPRD,
        MK_MRD,
        MK_MWR,
        MK_INT
    } kind_e;

    typedef enum logic [3:0] {
        AS_NONE,
        AS_PC,
        AS_MN,
        AS_MN1,
        AS_HL,
        AS_DE,
        AS_SP,
        AS_SP1,
        AS_SPM1,
        AS_SPM2
    } asel_e;

    typedef enum logic [1:0] {
        DS_NONE,
        DS_IDXL,
        DS_IDXH,
        DS_BYTE
    } dsel_e;

    typedef enum logic [2:0] {
        CS_NONE,
        CS_N,
        CS_M,
        CS_BYTE,
        CS_LO,
        CS_HI
    } csel_e;

    typedef struct packed {
        kind_e kind;
        asel_e asel;
        dsel_e dsel;
        csel_e csel;
        logic  last;
    } step_t;

    // Build one step descriptor.
    function automatic step_t mk_step(kind_e k, asel_e a, dsel_e d, csel_e c, logic l);
        step_t s;
        s.kind = k;
        s.asel = a;
        s.dsel = d;
        s.csel = c;
        s.last = l;
        return s;
    endfunction

endpackage

// File: rtl/busseq_plan.sv
// Machine-cycle plan: maps a selector and a machine-cycle index to the kind
// of cycle, its address source, its write-data source, its capture target
// and whether it is the final cycle. Purely combinational.
// Assumes: an index past the end of a sequence yields an inert last step.
module busseq_plan
    import busseq_pkg::*;
#(
    parameter int MCW = 3
) (
    input  sel_e           sel,
    input  logic [MCW-1:0] mc,
    output step_t          step
);

    localparam step_t FETCH = '{kind: MK_FETCH, asel: AS_PC, dsel: DS_NONE, csel: CS_NONE, last: 1'b0};
    localparam step_t INERT = '{kind: MK_INT, asel: AS_NONE, dsel: DS_NONE, csel: CS_NONE, last: 1'b1};

    // Look up the step for (sel, mc).
    always_comb begin
        step = INERT;
        unique case (sel)
            SEL_STIDX: begin
                case (mc)
                    MCW'(0), MCW'(1): step = FETCH;
                    MCW'(2):          step = mk_step(MK_OPRD, AS_PC,   DS_NONE, CS_N,    1'b0);
                    MCW'(3):          step = mk_step(MK_OPRD, AS_PC,   DS_NONE, CS_M,    1'b0);
                    MCW'(4):          step = mk_step(MK_INT,  AS_NONE, DS_NONE, CS_NONE, 1'b0);
                    MCW'(5):          step = mk_step(MK_MWR,  AS_MN,   DS_IDXL, CS_NONE, 1'b0);
                    MCW'(6):          step = mk_step(MK_MWR,  AS_MN1,  DS_IDXH, CS_NONE, 1'b1);
                    default:          step = INERT;
                endcase
            end
            SEL_HL2SP: begin
                case (mc)
                    MCW'(0): step = FETCH;
                    MCW'(1): step = mk_step(MK_INT, AS_NONE, DS_NONE, CS_NONE, 1'b1);
                    default: step = INERT;
                endcase
            end
            SEL_IX2SP: begin
                case (mc)
                    MCW'(0), MCW'(1): step = FETCH;
                    MCW'(2):          step = mk_step(MK_INT, AS_NONE, DS_NONE, CS_NONE, 1'b1);
                    default:          step = INERT;
                endcase
            end
            SEL_XINC, SEL_XDEC: begin
                case (mc)
                    MCW'(0), MCW'(1): step = FETCH;
                    MCW'(2):          step = mk_step(MK_MRD, AS_HL, DS_NONE, CS_BYTE, 1'b0);
                    MCW'(3):          step = mk_step(MK_MWR, AS_DE, DS_BYTE, CS_NONE, 1'b1);
                    default:          step = INERT;
                endcase
            end
            SEL_POP: begin
                case (mc)
                    MCW'(0), MCW'(1): step = FETCH;
                    MCW'(2):          step = mk_step(MK_MRD, AS_SP,  DS_NONE, CS_LO, 1'b0);
                    MCW'(3):          step = mk_step(MK_MRD, AS_SP1, DS_NONE, CS_HI, 1'b1);
                    default:          step = INERT;
                endcase
            end
            SEL_PUSH: begin
                case (mc)
                    MCW'(0), MCW'(1): step = FETCH;
                    MCW'(2):          step = mk_step(MK_MWR, AS_SPM1, DS_IDXH, CS_NONE, 1'b0);
                    MCW'(3):          step = mk_step(MK_MWR, AS_SPM2, DS_IDXL, CS_NONE, 1'b1);
                    default:          step = INERT;
                endcase
            end
            default: step = INERT;
        endcase
    end

endmodule

// File: rtl/busseq_timer.sv
// T-state and machine-cycle counter. Advances T1->T2->T3 for bus cycles and
// spends one clock in Ti for internal cycles, then steps to the next
// machine cycle or returns to idle after the final one.
// Assumes: accept is only raised while idle; the first cycle is a bus cycle.
module busseq_timer
    import busseq_pkg::*;
#(
    parameter int MCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           cur_last,
    input  logic           nxt_int,
    output ts_e            ts,
    output logic [MCW-1:0] mc,
    output logic           mc_end,
    output logic           finish
);

    localparam logic [MCW-1:0] MC_ONE = MCW'(1);

    // End of the current machine cycle and of the whole instruction.
    always_comb begin
        mc_end = (ts == TS_T3) || (ts == TS_TI);
        finish = mc_end && cur_last;
    end

    // Step the T-state and the machine-cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts <= TS_IDLE;
            mc <= '0;
        end else if (accept) begin
            ts <= TS_T1;
            mc <= '0;
        end else begin
            unique case (ts)
                TS_T1: ts <= TS_T2;
                TS_T2: ts <= TS_T3;
                TS_T3, TS_TI: begin
                    if (cur_last) begin
                        ts <= TS_IDLE;
                        mc <= '0;
                    end else begin
                        ts <= nxt_int ? TS_TI : TS_T1;
                        mc <= mc + MC_ONE;
                    end
                end
                default: ts <= TS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/busseq_regs.sv
// Register state of the sequencer: loads the caller's register values on
// accept, advances PC per fetched byte, captures read bytes at the end of
// read cycles and applies the instruction's register updates at finish.
// Assumes: captures happen only on read steps; finish is a single clock.
module busseq_regs
    import busseq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  sel_e         sel_in,
    input  logic [2*DW-1:0] pc_i,
    input  logic [2*DW-1:0] hl_i,
    input  logic [2*DW-1:0] de_i,
    input  logic [2*DW-1:0] bc_i,
    input  logic [2*DW-1:0] sp_i,
    input  logic [2*DW-1:0] idx_i,
    input  logic [DW-1:0]   rdata,
    input  step_t           step,
    input  logic            mc_end,
    input  logic            finish,
    output sel_e            sel_q,
    output logic [2*DW-1:0] pc_q,
    output logic [2*DW-1:0] hl_q,
    output logic [2*DW-1:0] de_q,
    output logic [2*DW-1:0] bc_q,
    output logic [2*DW-1:0] sp_q,
    output logic [2*DW-1:0] idx_q,
    output logic [2*DW-1:0] mn_q,
    output logic [DW-1:0]   xbyte_q
);

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    logic [DW-1:0] pop_lo_q;
    logic          fetch_like;

    // Cycles that consume a byte from the instruction stream.
    always_comb fetch_like = (step.kind == MK_FETCH) || (step.kind == MK_OPRD);

    // Load, capture and update the register set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= SEL_NONE;
            pc_q     <= '0;
            hl_q     <= '0;
            de_q     <= '0;
            bc_q     <= '0;
            sp_q     <= '0;
            idx_q    <= '0;
            mn_q     <= '0;
            xbyte_q  <= '0;
            pop_lo_q <= '0;
        end else if (accept) begin
            sel_q <= sel_in;
            pc_q  <= pc_i;
            hl_q  <= hl_i;
            de_q  <= de_i;
            bc_q  <= bc_i;
            sp_q  <= sp_i;
            idx_q <= idx_i;
        end else begin
            if (mc_end && fetch_like) begin
                pc_q <= pc_q + ONE;
            end
            if (mc_end) begin
                unique case (step.csel)
                    CS_N:    mn_q[DW-1:0]  <= rdata;
                    CS_M:    mn_q[AW-1:DW] <= rdata;
                    CS_BYTE: xbyte_q       <= rdata;
                    CS_LO:   pop_lo_q      <= rdata;
                    CS_HI:   idx_q         <= {rdata, pop_lo_q};
                    default: ;
                endcase
            end
            if (finish) begin
                unique case (sel_q)
                    SEL_HL2SP: sp_q <= hl_q;
                    SEL_IX2SP: sp_q <= idx_q;
                    SEL_XINC: begin
                        hl_q <= hl_q + ONE;
                        de_q <= de_q + ONE;
                        bc_q <= bc_q - ONE;
                    end
                    SEL_XDEC: begin
                        hl_q <= hl_q - ONE;
                        de_q <= de_q - ONE;
                        bc_q <= bc_q - ONE;
                    end
                    SEL_POP:  sp_q <= sp_q + TWO;
                    SEL_PUSH: sp_q <= sp_q - TWO;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/busseq_top.sv
// Instruction bus-cycle sequencer top. Accepts a start while idle, then
// drives address, write data, output enable and active-low strobes per
// T-state from the plan of the selected instruction. Pulses done one clock
// after the last T-state with the updated registers on the result ports.
// Assumes: rdata is valid at the end of T3 of read cycles; no wait states.
module busseq_top
    import busseq_pkg::*;
#(
    parameter int DW  = 8,
    parameter int MCW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        instr_sel,
    input  logic [2*DW-1:0]   pc_in,
    input  logic [2*DW-1:0]   hl_in,
    input  logic [2*DW-1:0]   de_in,
    input  logic [2*DW-1:0]   bc_in,
    input  logic [2*DW-1:0]   sp_in,
    input  logic [2*DW-1:0]   idx_in,
    input  logic [DW-1:0]     rdata,
    output logic [2*DW-1:0]   addr,
    output logic [DW-1:0]     dout,
    output logic              dout_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              mreq_n,
    output logic              m1_n,
    output logic [MCW-1:0]    mcyc,
    output logic [2:0]        tstate,
    output logic              busy,
    output logic              done,
    output logic [2*DW-1:0]   pc_out,
    output logic [2*DW-1:0]   hl_out,
    output logic [2*DW-1:0]   de_out,
    output logic [2*DW-1:0]   bc_out,
    output logic [2*DW-1:0]   sp_out,
    output logic [2*DW-1:0]   idx_out
);

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    ts_e            ts;
    logic [MCW-1:0] mc;
    logic           mc_end;
    logic           finish;
    logic           accept;
    sel_e           sel_in;
    sel_e           sel_q;
    step_t          step_v [2];
    step_t          cur;
    logic [AW-1:0]  pc_q, hl_q, de_q, bc_q, sp_q, idx_q, mn_q;
    logic [DW-1:0]  xbyte_q;
    logic           in_bus, late, rd_kind, wr_kind;
    logic [AW-1:0]  addr_mux;
    logic [DW-1:0]  data_mux;

    // Selector decode and start acceptance.
    always_comb begin
        sel_in = sel_e'(instr_sel);
        accept = start && (ts == TS_IDLE) && (sel_in != SEL_NONE);
    end

    // Plan lookups for the current and the following machine cycle.
    for (genvar g = 0; g < 2; g++) begin : g_plan
        busseq_plan #(.MCW(MCW)) u_plan (
            .sel  (sel_q),
            .mc   (mc + MCW'(g)),
            .step (step_v[g])
        );
    end

    always_comb cur = step_v[0];

    busseq_timer #(.MCW(MCW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cur_last (cur.last),
        .nxt_int  (step_v[1].kind == MK_INT),
        .ts       (ts),
        .mc       (mc),
        .mc_end   (mc_end),
        .finish   (finish)
    );

    busseq_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .sel_in  (sel_in),
        .pc_i    (pc_in),
        .hl_i    (hl_in),
        .de_i    (de_in),
        .bc_i    (bc_in),
        .sp_i    (sp_in),
        .idx_i   (idx_in),
        .rdata   (rdata),
        .step    (cur),
        .mc_end  (mc_end),
        .finish  (finish),
        .sel_q   (sel_q),
        .pc_q    (pc_q),
        .hl_q    (hl_q),
        .de_q    (de_q),
        .bc_q    (bc_q),
        .sp_q    (sp_q),
        .idx_q   (idx_q),
        .mn_q    (mn_q),
        .xbyte_q (xbyte_q)
    );

    // Address and write-data source selection.
    always_comb begin
        unique case (cur.asel)
            AS_PC:   addr_mux = pc_q;
            AS_MN:   addr_mux = mn_q;
            AS_MN1:  addr_mux = mn_q + ONE;
            AS_HL:   addr_mux = hl_q;
            AS_DE:   addr_mux = de_q;
            AS_SP:   addr_mux = sp_q;
            AS_SP1:  addr_mux = sp_q + ONE;
            AS_SPM1: addr_mux = sp_q - ONE;
            AS_SPM2: addr_mux = sp_q - TWO;
            default: addr_mux = '0;
        endcase
        unique case (cur.dsel)
            DS_IDXL: data_mux = idx_q[DW-1:0];
            DS_IDXH: data_mux = idx_q[AW-1:DW];
            DS_BYTE: data_mux = xbyte_q;
            default: data_mux = '0;
        endcase
    end

    // Strobe and bus-drive decode from T-state and cycle kind.
    always_comb begin
        in_bus  = (ts == TS_T1) || (ts == TS_T2) || (ts == TS_T3);
        late    = (ts == TS_T2) || (ts == TS_T3);
        rd_kind = (cur.kind == MK_FETCH) || (cur.kind == MK_OPRD) || (cur.kind == MK_MRD);
        wr_kind = (cur.kind == MK_MWR);
        mreq_n  = !(late && (rd_kind || wr_kind));
        rd_n    = !(late && rd_kind);
        wr_n    = !(late && wr_kind);
        m1_n    = !(in_bus && (cur.kind == MK_FETCH));
        dout_oe = in_bus && wr_kind;
        addr    = in_bus ? addr_mux : '0;
        dout    = dout_oe ? data_mux : '0;
        mcyc    = mc;
        tstate  = ts;
        busy    = (ts != TS_IDLE);
    end

    // Completion pulse, one clock after the last T-state.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= finish && busy;
    end

    // Result ports.
    always_comb begin
        pc_out  = pc_q;
        hl_out  = hl_q;
        de_out  = de_q;
        bc_out  = bc_q;
        sp_out  = sp_q;
        idx_out = idx_q;
    end

endmodule

// File: rtl/busseq_chk.sv
// Protocol checker for the sequencer, bound to busseq_top.
module busseq_chk
    import busseq_pkg::*;
#(
    parameter int MCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           done,
    input logic           rd_n,
    input logic           wr_n,
    input logic           mreq_n,
    input logic           m1_n,
    input logic           dout_oe,
    input logic [MCW-1:0] mcyc,
    input logic [2:0]     tstate
);

    // R1
    t1_to_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == TS_T1 |=> tstate == TS_T2);

    // R1
    t2_to_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == TS_T2 |=> tstate == TS_T3);

    // R1
    mcyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate == TS_T1 || tstate == TS_T2) |=> $stable(mcyc));

    // R2
    ti_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == TS_TI |-> (rd_n && wr_n && mreq_n && m1_n && !dout_oe));

    // R2
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_n == 1'b0 && wr_n == 1'b0));

    // R3
    m1_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m1_n |-> (wr_n && !dout_oe));

    // R4
    oe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> (rd_n && m1_n && tstate != TS_TI && tstate != TS_IDLE));

    // R11
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> tstate == TS_IDLE);

endmodule

bind busseq_top busseq_chk #(.MCW(MCW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .mreq_n  (mreq_n),
    .m1_n    (m1_n),
    .dout_oe (dout_oe),
    .mcyc    (mcyc),
    .tstate  (tstate)
);

// File: tb/busseq_top_tb.sv
`timescale 1ns/1ps
module busseq_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  instr_sel = 3'd0;
    logic [15:0] pc_in = '0, hl_in = '0, de_in = '0, bc_in = '0, sp_in = '0, idx_in = '0;
    logic [7:0]  rdata;
    logic [15:0] addr;
    logic [7:0]  dout;
    logic        dout_oe, rd_n, wr_n, mreq_n, m1_n, busy, done;
    logic [2:0]  mcyc, tstate;
    logic [15:0] pc_out, hl_out, de_out, bc_out, sp_out, idx_out;

    logic [7:0]  mem [0:255];
    int          n_chk = 0;
    int          n_fail = 0;

    typedef struct {
        logic [34:0] bus;
        string       tag;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    assign rdata = mem[addr[7:0]];

    busseq_top u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr_sel(instr_sel),
        .pc_in(pc_in), .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in),
        .sp_in(sp_in), .idx_in(idx_in), .rdata(rdata),
        .addr(addr), .dout(dout), .dout_oe(dout_oe), .rd_n(rd_n), .wr_n(wr_n),
        .mreq_n(mreq_n), .m1_n(m1_n), .mcyc(mcyc), .tstate(tstate),
        .busy(busy), .done(done), .pc_out(pc_out), .hl_out(hl_out),
        .de_out(de_out), .bc_out(bc_out), .sp_out(sp_out), .idx_out(idx_out)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [34:0] pack_bus(logic [15:0] a, logic oe, logic [7:0] d, logic rn, logic wn,
                                             logic mq, logic m1, logic [2:0] mc, logic [2:0] ts);
        return {a, oe, d, rn, wn, mq, m1, mc, ts};
    endfunction

    // Push the expected clocks of one machine cycle. kind: 0 fetch, 1 operand
    // read, 2 data read, 3 write, 4 internal. (R1 R2 R3 R4)
    task automatic push_mc(input int kind, input logic [15:0] a, input logic [7:0] d,
                           input logic [2:0] mc, input string tag);
        item_t it;
        it.tag = tag;
        if (kind == 4) begin
            it.bus = pack_bus(16'h0, 1'b0, 8'h0, 1'b1, 1'b1, 1'b1, 1'b1, mc, 3'd4);
            exp_q.push_back(it);
        end else begin
            for (int t = 1; t <= 3; t++) begin
                logic late;
                logic wr;
                late = (t >= 2);
                wr = (kind == 3);
                it.bus = pack_bus(a, wr, wr ? d : 8'h0, !(late && !wr), !(late && wr), !late,
                                  !(kind == 0), mc, 3'(t));
                exp_q.push_back(it);
            end
        end
    endtask

    // Monitor: compare each busy clock against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && busy) begin
            logic [34:0] act;
            act = pack_bus(addr, dout_oe, dout, rd_n, wr_n, mreq_n, m1_n, mcyc, tstate);
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected busy clock", {29'd0, act}, 64'd0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(act == e.bus, e.tag, {29'd0, act}, {29'd0, e.bus});
            end
        end
    end

    // Driver: build the expected sequence, start, wait for done, check results.
    task automatic run(input logic [2:0] s, input logic [15:0] pc, hl, de, bc, sp, idx,
                       input logic [15:0] aux, input bit glitch, input string tag);
        logic [15:0] p, e_pc, e_hl, e_de, e_bc, e_sp, e_idx;
        int w;
        p = pc;
        e_hl = hl; e_de = de; e_bc = bc; e_sp = sp; e_idx = idx;
        case (s)
            3'd0: begin // R5 store index to direct address
                mem[8'(pc + 16'd2)] = aux[7:0];
                mem[8'(pc + 16'd3)] = aux[15:8];
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(0, p, 0, 1, tag); p++;
                push_mc(1, p, 0, 2, tag); p++;
                push_mc(1, p, 0, 3, tag); p++;
                push_mc(4, 0, 0, 4, tag);
                push_mc(3, aux, idx[7:0], 5, tag);
                push_mc(3, aux + 16'd1, idx[15:8], 6, tag);
            end
            3'd1: begin // R6 HL to SP
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(4, 0, 0, 1, tag);
                e_sp = hl;
            end
            3'd2: begin // R6 index to SP
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(0, p, 0, 1, tag); p++;
                push_mc(4, 0, 0, 2, tag);
                e_sp = idx;
            end
            3'd3, 3'd4: begin // R7 block transfer
                mem[hl[7:0]] = aux[7:0];
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(0, p, 0, 1, tag); p++;
                push_mc(2, hl, 0, 2, tag);
                push_mc(3, de, aux[7:0], 3, tag);
                e_hl = (s == 3'd3) ? hl + 16'd1 : hl - 16'd1;
                e_de = (s == 3'd3) ? de + 16'd1 : de - 16'd1;
                e_bc = bc - 16'd1;
            end
            3'd5: begin // R8 pop
                mem[sp[7:0]] = aux[7:0];
                mem[8'(sp + 16'd1)] = aux[15:8];
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(0, p, 0, 1, tag); p++;
                push_mc(2, sp, 0, 2, tag);
                push_mc(2, sp + 16'd1, 0, 3, tag);
                e_sp = sp + 16'd2;
                e_idx = aux;
            end
            default: begin // R9 push
                push_mc(0, p, 0, 0, tag); p++;
                push_mc(0, p, 0, 1, tag); p++;
                push_mc(3, sp - 16'd1, idx[15:8], 2, tag);
                push_mc(3, sp - 16'd2, idx[7:0], 3, tag);
                e_sp = sp - 16'd2;
            end
        endcase
        e_pc = p;
        @(negedge clk);
        instr_sel = s; pc_in = pc; hl_in = hl; de_in = de; bc_in = bc; sp_in = sp; idx_in = idx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (glitch) begin // R12 start while busy is ignored
            repeat (2) @(negedge clk);
            start = 1'b1; instr_sel = 3'd1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!done && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(done == 1'b1, {tag, " R11 done seen"}, {63'd0, done}, 64'd1);
        check(exp_q.size() == 0, {tag, " R11 done after last T-state"}, exp_q.size(), 64'd0);
        check(busy == 1'b0, {tag, " R11 idle with done"}, {63'd0, busy}, 64'd0);
        check(pc_out == e_pc, {tag, " R10 pc"}, pc_out, e_pc);
        check(hl_out == e_hl, {tag, " hl"}, hl_out, e_hl);
        check(de_out == e_de, {tag, " de"}, de_out, e_de);
        check(bc_out == e_bc, {tag, " bc"}, bc_out, e_bc);
        check(sp_out == e_sp, {tag, " sp"}, sp_out, e_sp);
        check(idx_out == e_idx, {tag, " idx"}, idx_out, e_idx);
        exp_q.delete();
        @(negedge clk);
        check(done == 1'b0, {tag, " R11 done one clock"}, {63'd0, done}, 64'd0);
        check(busy == 1'b0, {tag, " R12 no restart"}, {63'd0, busy}, 64'd0);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #100000;
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h3C);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R4 reset state
        check({busy, done, tstate} == 5'b0, "R1 reset idle", {59'd0, busy, done, tstate}, 64'd0);
        check({rd_n, wr_n, mreq_n, m1_n, dout_oe} == 5'b11110, "R2 reset strobes",
              {59'd0, rd_n, wr_n, mreq_n, m1_n, dout_oe}, 64'b11110);
        check(addr == 16'h0 && dout == 8'h0, "R4 reset bus", {40'd0, addr, dout}, 64'd0);

        run(3'd0, 16'h0100, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'hBEEF, 16'h2040, 1'b0, "R5 store");
        run(3'd1, 16'h0180, 16'h1234, 16'h0000, 16'h0001, 16'hF000, 16'h5555, 16'h0, 1'b0, "R6 hl2sp");
        run(3'd2, 16'h01C0, 16'h0F0F, 16'h0000, 16'h0001, 16'hF000, 16'h8001, 16'h0, 1'b0, "R6 ix2sp");
        run(3'd3, 16'h0200, 16'h0030, 16'h0050, 16'h0003, 16'h0000, 16'h0000, 16'h005A, 1'b0, "R7 xinc");
        run(3'd4, 16'h0210, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h00C3, 1'b0, "R7 xdec wrap");
        run(3'd5, 16'h0220, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h1357, 16'h7E81, 1'b0, "R8 pop wrap");
        run(3'd6, 16'h0230, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hA55A, 16'h0, 1'b0, "R9 push wrap");
        run(3'd0, 16'h0240, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0C0D, 16'h90FF, 1'b1, "R12 store busy start");

        // R12 selector 7 is ignored
        @(negedge clk);
        instr_sel = 3'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0 && tstate == 3'd0, "R12 selector 7", {60'd0, busy, tstate}, 64'd0);
        check(rd_n && mreq_n && m1_n, "R12 selector 7 strobes", {61'd0, rd_n, mreq_n, m1_n}, 64'd7);
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R12 selector 7 no done", {63'd0, done}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule